// File: doc/BRIEF.md
# Polarity-Controlled Input Gate Stage

This block sits between the source-selection multiplexers and the logic function of a configurable logic cell. It receives four selected data bits and forms both the true and the complemented copy of each, which gives eight candidate signals. Four independent gates each OR together whichever of the eight candidates their enable bits pick. A per-gate inversion then decides the final level. With this one structure software can build OR, NOR, AND, NAND, single-signal inversion or a fixed 0 or 1 for each of the four outputs that feed the logic function.

Configuration sits in two registers, reached through a single-cycle write strobe: a 32-bit enable word and a 4-bit inversion word. The gate outputs are purely combinational from the data bits and the stored configuration. Only configuration changes wait for a clock edge.

Top module: `lig_input_gates`

## Requirements
- R1: After reset the enable word and the inversion word are both zero, so all four gate outputs are 0 for every data value.
- R2: Gate g (0..3) takes its enables from bits [8g+7:8g] of the enable word. Inside that byte, bit 2k enables the complement of data bit k and bit 2k+1 enables the true data bit k.
- R3: Each gate output equals the OR of its enabled candidate signals, inverted when the gate's inversion bit (bit g of the inversion word) is 1. Any mix of the eight enables may be set at once.
- R4: A gate whose eight enables are all clear outputs a constant equal to its inversion bit, whatever the data.
- R5: An enable byte of 0xAA (true signals only) gives the OR of the four data bits with inversion 0, and their NOR with inversion 1.
- R6: An enable byte of 0x55 (complements only) gives the NAND of the four data bits with inversion 0, and their AND with inversion 1.
- R7: A write with address 0 loads all 32 data bits into the enable word. A write with address 1 loads data bits [3:0] into the inversion word and ignores bits [31:4]. Each write changes only its own register, and the new value appears at the outputs after the clock edge where the strobe was high. Without a strobe both registers hold.
- R8: A change on the data inputs reaches the gate outputs in the same cycle, with no clock edge in between.
- R9: The four gates are independent: each follows only its own enable byte and its own inversion bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration registers |
| cfg_addr | input | 1 | 0 = enable word, 1 = inversion word |
| cfg_wdata | input | 32 | Write data |
| data_in | input | 4 | Selected data bits, bit k is source k |
| gate_out | output | 4 | Gate results, bit g from gate g |

## Verification
A configuration write and a change of the data inputs can fall in the same cycle. In that case the outputs must show the new data with the old configuration until the edge, and the new configuration after it. The bench provokes this by driving a new data value at the same negative edge where it raises the write strobe. A behavioural model keeps its own copy of both registers, updated at the clock edge, and recomputes every gate from the enable and data bits one position at a time. The design is compared with that model shortly after every rising edge and after every mid-cycle data change.

// File: rtl/lig_pkg.sv
package lig_pkg;

  localparam int unsigned LIG_GATES_DEF = 4;
  localparam int unsigned LIG_SRCS_DEF  = 4;

  typedef enum logic {
    CFG_ENABLES   = 1'b0,
    CFG_INVERSION = 1'b1
  } cfg_addr_e;

endpackage

// File: rtl/lig_cfg_regs.sv
module lig_cfg_regs #(
  parameter int unsigned N_GATES = 4,
  parameter int unsigned SEL_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               addr,
  input  logic [SEL_W-1:0]   wdata,
  output logic [SEL_W-1:0]   sel_q,
  output logic [N_GATES-1:0] pol_q
);
  import lig_pkg::*;

  logic sel_wr_evt;
  logic pol_wr_evt;

  assign sel_wr_evt = we && (cfg_addr_e'(addr) == CFG_ENABLES);
  assign pol_wr_evt = we && (cfg_addr_e'(addr) == CFG_INVERSION);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_wr_evt) begin
      sel_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
    end else if (pol_wr_evt) begin
      pol_q <= wdata[N_GATES-1:0];
    end
  end

  // R7: enable write lands on the next edge and leaves inversion alone
  p_sel_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr_evt |=> (sel_q == $past(wdata)) && $stable(pol_q));

  // R7: inversion write takes only the low bits and leaves enables alone
  p_pol_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pol_wr_evt |=> (pol_q == $past(wdata[N_GATES-1:0])) && $stable(sel_q));

  // R7: without a strobe both registers hold
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(sel_q) && $stable(pol_q));

endmodule

// File: rtl/lig_gate.sv
module lig_gate #(
  parameter int unsigned N_SRC = 4,
  localparam int unsigned CAND_W = 2 * N_SRC
) (
  input  logic [N_SRC-1:0]  d,
  input  logic [CAND_W-1:0] en,
  input  logic              inv,
  output logic              raw_or,
  output logic              y
);

  // Interleave complement (even position) and true (odd position) per source
  function automatic logic [CAND_W-1:0] make_candidates(input logic [N_SRC-1:0] src);
    logic [CAND_W-1:0] c;
    for (int k = 0; k < int'(N_SRC); k++) begin
      c[2*k]   = ~src[k];
      c[2*k+1] =  src[k];
    end
    return c;
  endfunction

  logic [CAND_W-1:0] cand;
  logic [CAND_W-1:0] picked;

  assign cand   = make_candidates(d);
  assign picked = cand & en;
  assign raw_or = |picked;
  assign y      = raw_or ^ inv;

endmodule

// File: rtl/lig_input_gates.sv
module lig_input_gates #(
  parameter int unsigned N_GATES = lig_pkg::LIG_GATES_DEF,
  parameter int unsigned N_SRC   = lig_pkg::LIG_SRCS_DEF,
  localparam int unsigned CAND_W = 2 * N_SRC,
  localparam int unsigned SEL_W  = N_GATES * CAND_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_addr,
  input  logic [SEL_W-1:0]   cfg_wdata,
  input  logic [N_SRC-1:0]   data_in,
  output logic [N_GATES-1:0] gate_out
);

  function automatic logic [CAND_W-1:0] parity_mask(input bit odd);
    logic [CAND_W-1:0] m;
    for (int i = 0; i < int'(CAND_W); i++) begin
      m[i] = ((i % 2) == 1) == odd;
    end
    return m;
  endfunction

  localparam logic [CAND_W-1:0] TRUE_ONLY  = parity_mask(1'b1);
  localparam logic [CAND_W-1:0] COMPL_ONLY = parity_mask(1'b0);

  logic [SEL_W-1:0]   sel_q;
  logic [N_GATES-1:0] pol_q;
  logic [N_GATES-1:0] raw_or;

  lig_cfg_regs #(
    .N_GATES (N_GATES),
    .SEL_W   (SEL_W)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .sel_q (sel_q),
    .pol_q (pol_q)
  );

  for (genvar g = 0; g < int'(N_GATES); g++) begin : g_gate
    logic [CAND_W-1:0] en_byte;
    assign en_byte = sel_q[g*CAND_W +: CAND_W];

    lig_gate #(
      .N_SRC (N_SRC)
    ) u_gate (
      .d      (data_in),
      .en     (en_byte),
      .inv    (pol_q[g]),
      .raw_or (raw_or[g]),
      .y      (gate_out[g])
    );

    // R4: nothing enabled gives the inversion bit as a constant
    p_const_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_byte == '0) |-> (gate_out[g] == pol_q[g]));

    // R5: true-only enables without inversion give OR of the data
    p_or_pattern_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_byte == TRUE_ONLY && !pol_q[g]) |-> (gate_out[g] == (|data_in)));

    // R6: complement-only enables with inversion give AND of the data
    p_and_pattern_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_byte == COMPL_ONLY && pol_q[g]) |-> (gate_out[g] == (&data_in)));

    // R3: any hit in the OR with inversion clear drives a 1
    p_hit_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_or[g] && !pol_q[g]) |-> gate_out[g]);
  end

endmodule

// File: tb/lig_input_gates_bench.sv
`timescale 1ns/1ps
module lig_input_gates_bench;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic        cfg_addr;
  logic [31:0] cfg_wdata;
  logic [3:0]  data_in;
  logic [3:0]  gate_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [31:0] m_sel;
  logic [3:0]  m_pol;

  lig_input_gates u_lig_input_gates (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .data_in   (data_in),
    .gate_out  (gate_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural register model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel <= 32'h0;
      m_pol <= 4'h0;
    end else if (cfg_we) begin
      if (cfg_addr == 1'b0) m_sel <= cfg_wdata;
      else                  m_pol <= cfg_wdata[3:0];
    end
  end

  function automatic bit ref_gate(int g, logic [31:0] s, logic [3:0] p, logic [3:0] d);
    bit hit = 0;
    for (int k = 0; k < 4; k++) begin
      if (s[g*8 + 2*k + 1] && d[k] == 1'b1) hit = 1;
      if (s[g*8 + 2*k]     && d[k] == 1'b0) hit = 1;
    end
    return hit ^ p[g];
  endfunction

  task automatic check_bit(string req, int g, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s gate=%0d data=%b actual=%b expected=%b", req, g, data_in, act, exp);
    end
  endtask

  task automatic compare_model(string req);
    for (int g = 0; g < 4; g++)
      check_bit(req, g, gate_out[g], ref_gate(g, m_sel, m_pol, data_in));
  endtask

  // Per-cycle comparison against the model (R3, R2)
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) compare_model("R3");
  end

  task automatic cfg_write(logic a, logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = 32'h0;
  endtask

  // kind: 0 OR,1 NOR,2 NAND,3 AND,4 NOT d0,5 const0,6 const1
  task automatic run_table(string req, logic [31:0] s, logic [3:0] p, int kind);
    cfg_write(1'b0, s);
    cfg_write(1'b1, {28'h0, p});
    for (int v = 0; v < 16; v++) begin
      logic e;
      @(negedge clk);
      data_in = v[3:0];
      #1;
      case (kind)
        0: e = |data_in;
        1: e = ~|data_in;
        2: e = ~&data_in;
        3: e = &data_in;
        4: e = ~data_in[0];
        5: e = 1'b0;
        default: e = 1'b1;
      endcase
      for (int g = 0; g < 4; g++) check_bit(req, g, gate_out[g], e);
    end
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = 32'h0; data_in = 4'h0;
    repeat (3) @(negedge clk);
    // R1: reset state, all outputs 0 for every data value
    for (int v = 0; v < 16; v++) begin
      data_in = v[3:0];
      #1;
      for (int g = 0; g < 4; g++) check_bit("R1", g, gate_out[g], 1'b0);
    end
    rst_n = 1'b1;

    // Function table (R5, R6, R4)
    run_table("R5", 32'hAAAAAAAA, 4'h0, 0);
    run_table("R5", 32'hAAAAAAAA, 4'hF, 1);
    run_table("R6", 32'h55555555, 4'h0, 2);
    run_table("R6", 32'h55555555, 4'hF, 3);
    run_table("R2", 32'h02020202, 4'hF, 4);
    run_table("R4", 32'h00000000, 4'h0, 5);
    run_table("R4", 32'h00000000, 4'hF, 6);

    // R9 and R2: every gate configured differently
    cfg_write(1'b0, 32'h00_80_01_AA);
    cfg_write(1'b1, 32'h0000_0008);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); data_in = v[3:0]; #1;
      check_bit("R9", 0, gate_out[0], |data_in);
      check_bit("R9", 1, gate_out[1], ~data_in[0]);
      check_bit("R9", 2, gate_out[2], data_in[3]);
      check_bit("R9", 3, gate_out[3], 1'b1);
    end

    // R3: mixed enables, true d1 plus complement d2, inversion on gate 0
    cfg_write(1'b0, 32'h0000_0018);
    cfg_write(1'b1, 32'h0000_0001);
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); data_in = v[3:0]; #1;
      check_bit("R3", 0, gate_out[0], ~(data_in[1] | ~data_in[2]));
    end

    // R7: upper inversion bits ignored, enable word untouched by inversion write
    cfg_write(1'b0, 32'h0);
    cfg_write(1'b1, 32'h0);
    cfg_write(1'b1, 32'hFFFF_FFF0);
    #1;
    for (int g = 0; g < 4; g++) check_bit("R7", g, gate_out[g], 1'b0);

    // R7: write and data change in the same cycle, visible only after the edge
    @(negedge clk);
    data_in = 4'h0;
    cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = 32'h0000_0005;
    #1;
    for (int g = 0; g < 4; g++) check_bit("R7", g, gate_out[g], 1'b0);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    for (int g = 0; g < 4; g++) check_bit("R7", g, gate_out[g], (g % 2) == 0);

    // R8: data change without clock edge reaches outputs
    cfg_write(1'b0, 32'h2000_0000);
    cfg_write(1'b1, 32'h0);
    @(negedge clk);
    data_in = 4'h4;
    #1;
    check_bit("R8", 3, gate_out[3], 1'b1);
    #2;
    data_in = 4'h0;
    #1;
    check_bit("R8", 3, gate_out[3], 1'b0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule